// File: doc/BRIEF.md
# Dual-Compare 8-bit Event Timer

The block is a free-running up-counter with two compare registers. Each comparison sets its own sticky event flag when a count tick carries the counter onto the compare value, and a third flag records the wrap from the all-ones value to zero. The flags drive interrupt request lines. Software may clear a flag only by reading it as 1 and then writing 0 to it. A transfer-controller acknowledge can also clear the two compare flags. On every compare event, a selectable action is applied to one timer output pin: keep, drive low, drive high or toggle. When it is enabled, compare A also issues a one-cycle conversion start pulse for an A/D converter.

Software reaches the block over a single-cycle register bus. The address map is 0 = control/status, 1 = counter, 2 = compare A and 3 = compare B. Reads return data combinationally. Writes take effect at the next clock edge. Control/status bit 7 is flag B, bit 6 is flag A, bit 5 is the overflow flag and bit 4 is the A/D trigger enable. Bits 3:2 hold the action for compare B and bits 1:0 hold the action for compare A.

Top module: `dcmp_timer`

## Requirements
- R1: On each cycle with `tick_i` high, the counter advances by one and wraps from all-ones to zero. Without a tick it holds its value. A bus write to address 1 loads the counter instead, takes precedence over a tick, and produces no compare or overflow event.
- R2: After reset the counter reads 0, both compare registers read 0xFF, control/status reads 0x00, the pin is low and all interrupt lines are low.
- R3: Flag A (bit 6) sets at the same edge at which a tick moves the counter onto the compare A value. Flag B (bit 7) does the same for compare B.
- R4: The overflow flag (bit 5) sets at the edge at which a tick wraps the counter from all-ones to zero.
- R5: A read of address 0 that returns a flag as 1 arms that flag. A later write to address 0 with that bit at 0 clears it. Any write to address 0 disarms all flags. Writing 1 to a flag bit, or writing 0 to a flag that is not armed, leaves the flag unchanged.
- R6: `ack_a_i` clears flag A and `ack_b_i` clears flag B at the next edge while `ack_dis_i` is low. While `ack_dis_i` is high, neither acknowledge has any effect.
- R7: A flag that is set and cleared in the same cycle ends up set.
- R8: With bit 4 at 1, `adc_start_o` pulses high for exactly one cycle at the edge at which flag A sets. With bit 4 at 0, no pulse is issued.
- R9: The pin action codes are 00 keep, 01 drive low, 10 drive high and 11 toggle. Bits 1:0 select the action for compare A and bits 3:2 select the action for compare B. The pin changes at the edge at which the matching flag would set.
- R10: When both compares match in the same cycle and B selects drive low or drive high, B's action applies. Otherwise, if either compare selects toggle, the pin toggles exactly once. With no compare event the pin holds its value.
- R11: `irq_a_o`, `irq_b_o` and `irq_ovf_o` follow flags A, B and overflow.
- R12: With `HAS_ADC` = 0, bit 4 always reads 1, ignores writes, and `adc_start_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one increment per cycle high |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (arms flags read at address 0) |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data, combinational from address |
| ack_a_i | input | 1 | Transfer acknowledge for compare A |
| ack_b_i | input | 1 | Transfer acknowledge for compare B |
| ack_dis_i | input | 1 | When high, acknowledges do not clear flags |
| tmr_pin_o | output | 1 | Timer output pin |
| adc_start_o | output | 1 | A/D conversion start pulse |
| irq_a_o | output | 1 | Compare A interrupt request |
| irq_b_o | output | 1 | Compare B interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |

## Verification
Every registered result is due one edge after its cause. The counter, the flags, the pin and the A/D pulse all change at the edge that ends the tick, write or acknowledge cycle. Read data is due in the same cycle as the address. The bench drives all inputs on the falling edge and samples registered outputs on the next falling edge, which is half a period after the edge that updated them. It samples read data 1 time unit after setting the address, before the arming edge. The A/D pulse is checked at its edge and again one cycle later, to confirm that it lasts a single cycle.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CSR = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 2'd3;

  localparam int BIT_FB = 7;
  localparam int BIT_FA = 6;
  localparam int BIT_FO = 5;
  localparam int BIT_ADTE = 4;
  localparam int NUM_FLAGS = 3;  // index 2 = B, 1 = A, 0 = overflow

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;
endpackage

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cmp_a_o,
  output logic [CNT_W-1:0]  cmp_b_o,
  output logic              ev_a_o,
  output logic              ev_b_o,
  output logic              ev_ovf_o
);
  logic [CNT_W-1:0] cnt_q, cmp_a_q, cmp_b_q, cnt_nxt;
  logic cnt_wr, adv;

  assign cnt_wr  = wr_i && (addr_i == ADDR_CNT);
  assign adv     = tick_i && !cnt_wr;
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cmp_a_q <= '1;
      cmp_b_q <= '1;
    end else begin
      if (cnt_wr)   cnt_q <= wdata_i;
      else if (adv) cnt_q <= cnt_nxt;
      if (wr_i && addr_i == ADDR_CMPA) cmp_a_q <= wdata_i;
      if (wr_i && addr_i == ADDR_CMPB) cmp_b_q <= wdata_i;
    end
  end

  // events fire on the cycle whose edge lands the counter on the value
  assign ev_a_o   = adv && (cnt_nxt == cmp_a_q);
  assign ev_b_o   = adv && (cnt_nxt == cmp_b_q);
  assign ev_ovf_o = adv && (cnt_q == '1);

  assign cnt_o   = cnt_q;
  assign cmp_a_o = cmp_a_q;
  assign cmp_b_o = cmp_b_q;

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr && cnt_q == '1) |=> (cnt_q == '0)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr) |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/dct_flags.sv
module dct_flags
  import dct_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 csr_wr_i,
  input  logic                 csr_rd_i,
  input  logic [NUM_FLAGS-1:0] wflags_i,
  input  logic                 ack_a_i,
  input  logic                 ack_b_i,
  input  logic                 ack_dis_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic [NUM_FLAGS-1:0] flag_q, arm_q, ack_v;

  assign ack_v = {ack_b_i && !ack_dis_i, ack_a_i && !ack_dis_i, 1'b0};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic clr;
    assign clr = (csr_wr_i && arm_q[i] && !wflags_i[i]) || ack_v[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        flag_q[i] <= set_i[i] || (flag_q[i] && !clr);  // set wins
        if (csr_wr_i)                   arm_q[i] <= 1'b0;
        else if (csr_rd_i && flag_q[i]) arm_q[i] <= 1'b1;
      end
    end

    AST_FLAG_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[i]) |-> $past(set_i[i])); // R3
    AST_FLAG_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_q[i]) |-> $past(csr_wr_i || ack_v[i])); // R5
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]); // R7
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/dct_pin.sv
module dct_pin
  import dct_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ev_a_i,
  input  logic     ev_b_i,
  input  pin_act_e os_a_i,
  input  pin_act_e os_b_i,
  output logic     pin_o
);
  pin_act_e act_a, act_b;
  logic pin_q, pin_d;

  assign act_a = ev_a_i ? os_a_i : ACT_KEEP;
  assign act_b = ev_b_i ? os_b_i : ACT_KEEP;

  always_comb begin
    pin_d = pin_q;
    if (act_b == ACT_LOW || act_b == ACT_HIGH) pin_d = (act_b == ACT_HIGH);
    else if (act_a == ACT_TOGGLE || act_b == ACT_TOGGLE) pin_d = !pin_q;
    else if (act_a == ACT_LOW || act_a == ACT_HIGH) pin_d = (act_a == ACT_HIGH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  AST_PIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_a_i && !ev_b_i) |=> $stable(pin_q)); // R10
  AST_PIN_B_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_b_i && os_b_i == ACT_HIGH) |=> pin_q); // R10
  AST_PIN_B_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_b_i && os_b_i == ACT_LOW) |=> !pin_q); // R10
endmodule

// File: rtl/dcmp_timer.sv
module dcmp_timer
  import dct_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter bit HAS_ADC = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  input  logic              ack_a_i,
  input  logic              ack_b_i,
  input  logic              ack_dis_i,
  output logic              tmr_pin_o,
  output logic              adc_start_o,
  output logic              irq_a_o,
  output logic              irq_b_o,
  output logic              irq_ovf_o
);
  logic [CNT_W-1:0] cnt, cmp_a, cmp_b, csr_v;
  logic ev_a, ev_b, ev_ovf, csr_wr, csr_rd, adte, adte_rd;
  logic [NUM_FLAGS-1:0] flags;
  pin_act_e os_a_q, os_b_q;

  assign csr_wr = reg_wr_i && (reg_addr_i == ADDR_CSR);
  assign csr_rd = reg_rd_i && (reg_addr_i == ADDR_CSR);

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cnt_o(cnt), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b),
    .ev_a_o(ev_a), .ev_b_o(ev_b), .ev_ovf_o(ev_ovf)
  );

  dct_flags u_flags (
    .clk_i, .rst_ni,
    .set_i({ev_b, ev_a, ev_ovf}),
    .csr_wr_i(csr_wr), .csr_rd_i(csr_rd),
    .wflags_i(reg_wdata_i[BIT_FB:BIT_FO]),
    .ack_a_i, .ack_b_i, .ack_dis_i,
    .flags_o(flags)
  );

  dct_pin u_pin (
    .clk_i, .rst_ni, .ev_a_i(ev_a), .ev_b_i(ev_b),
    .os_a_i(os_a_q), .os_b_i(os_b_q), .pin_o(tmr_pin_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      os_a_q <= ACT_KEEP;
      os_b_q <= ACT_KEEP;
    end else if (csr_wr) begin
      os_a_q <= pin_act_e'(reg_wdata_i[1:0]);
      os_b_q <= pin_act_e'(reg_wdata_i[3:2]);
    end
  end

  if (HAS_ADC) begin : g_adc
    logic adte_q, adc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        adte_q <= 1'b0;
        adc_q  <= 1'b0;
      end else begin
        if (csr_wr) adte_q <= reg_wdata_i[BIT_ADTE];
        adc_q <= ev_a && adte_q;
      end
    end
    assign adte        = adte_q;
    assign adte_rd     = adte_q;
    assign adc_start_o = adc_q;

    AST_ADC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adc_start_o |-> $past(ev_a && adte)); // R8
    AST_ADC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adc_start_o |-> irq_a_o); // R8
  end else begin : g_no_adc
    assign adte        = 1'b0;
    assign adte_rd     = 1'b1;  // reserved bit reads 1
    assign adc_start_o = adte;
  end

  always_comb begin
    csr_v = '0;
    csr_v[BIT_FB:BIT_FO] = flags;
    csr_v[BIT_ADTE] = adte_rd;
    csr_v[3:2] = os_b_q;
    csr_v[1:0] = os_a_q;
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CSR:  reg_rdata_o = csr_v;
      ADDR_CNT:  reg_rdata_o = cnt;
      ADDR_CMPA: reg_rdata_o = cmp_a;
      default:   reg_rdata_o = cmp_b;
    endcase
  end

  assign irq_b_o   = flags[2];
  assign irq_a_o   = flags[1];
  assign irq_ovf_o = flags[0];

  AST_IRQ_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_ovf_o) |-> $past(tick_i && cnt == '1)); // R4
endmodule

// File: tb/tb_dcmp_timer.sv
module tb_dcmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wdata = '0, rdata, rdata2;
  logic ack_a = 1'b0, ack_b = 1'b0, ack_dis = 1'b0;
  logic pin, adc, irq_a, irq_b, irq_o;
  logic pin2, adc2, irq_a2, irq_b2, irq_o2;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcmp_timer #(.CNT_W(W), .HAS_ADC(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_addr_i(addr),
    .reg_wr_i(wr_en), .reg_rd_i(rd_en), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_a_i(ack_a), .ack_b_i(ack_b), .ack_dis_i(ack_dis),
    .tmr_pin_o(pin), .adc_start_o(adc), .irq_a_o(irq_a), .irq_b_o(irq_b),
    .irq_ovf_o(irq_o));

  dcmp_timer #(.CNT_W(W), .HAS_ADC(1'b0)) dut_noadc (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_addr_i(addr),
    .reg_wr_i(wr_en), .reg_rd_i(rd_en), .reg_wdata_i(wdata), .reg_rdata_o(rdata2),
    .ack_a_i(ack_a), .ack_b_i(ack_b), .ack_dis_i(ack_dis),
    .tmr_pin_o(pin2), .adc_start_o(adc2), .irq_a_o(irq_a2), .irq_b_o(irq_b2),
    .irq_ovf_o(irq_o2));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d, output logic [W-1:0] d2);
    addr = a; rd_en = 1'b1;
    #1 d = rdata; d2 = rdata2;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d, d2;
    rd(0, d, d2); chk("R2 csr", d, 8'h00); chk("R12 reserved bit reads 1", d2, 8'h10);
    rd(1, d, d2); chk("R2 cnt", d, 8'h00);
    rd(2, d, d2); chk("R2 cmpa", d, 8'hFF);
    rd(3, d, d2); chk("R2 cmpb", d, 8'hFF);
    chk("R2 pin", W'(pin), 0);
    chk("R2 irqs", W'({irq_a, irq_b, irq_o}), 0);
  endtask

  task automatic t_count();
    logic [W-1:0] d, d2;
    ticks(5);
    rd(1, d, d2); chk("R1 count 5 ticks", d, 8'd5);
    @(negedge clk);
    rd(1, d, d2); chk("R1 hold without tick", d, 8'd5);
    wr(1, 8'h80);
    rd(1, d, d2); chk("R1 load", d, 8'h80);
  endtask

  task automatic t_match_a();
    logic [W-1:0] d, d2;
    wr(0, 8'h10); wr(2, 8'h10); wr(1, 8'h0E);
    ticks(1); chk("R3 no flag before match", W'(irq_a), 0);
    ticks(1);
    chk("R3 flag A set at match", W'(irq_a), 1);
    chk("R8 adc pulse", W'(adc), 1);
    chk("R12 no adc pulse in variant", W'(adc2), 0);
    @(negedge clk); chk("R8 adc one cycle", W'(adc), 0);
    rd(1, d, d2); chk("R1 counter at match value", d, 8'h10);
  endtask

  task automatic t_clear_rule();
    logic [W-1:0] d, d2;
    wr(0, 8'hF0); chk("R5 writing 1 no effect", W'(irq_a), 1);
    wr(0, 8'h10); chk("R5 unarmed write 0 no effect", W'(irq_a), 1);
    rd(0, d, d2); chk("R11 csr shows flag A", d, 8'h50);
    wr(0, 8'h10); chk("R5 armed write 0 clears", W'(irq_a), 0);
    rd(0, d, d2); chk("R5 csr after clear", d, 8'h10);
  endtask

  task automatic t_ack();
    wr(3, 8'h20); wr(1, 8'h1F); ticks(1);
    chk("R3 flag B set", W'(irq_b), 1);
    chk("R3 flag A not set by B", W'(irq_a), 0);
    ack_b = 1'b1; ack_dis = 1'b1; @(negedge clk); ack_b = 1'b0; ack_dis = 1'b0;
    chk("R6 ack with disable no effect", W'(irq_b), 1);
    ack_b = 1'b1; @(negedge clk); ack_b = 1'b0;
    chk("R6 ack clears B", W'(irq_b), 0);
  endtask

  task automatic t_ovf();
    logic [W-1:0] d, d2;
    wr(1, 8'hFE); ticks(1);
    chk("R4 no overflow at FF", W'(irq_o), 0);
    ticks(1);
    chk("R4 overflow flag set", W'(irq_o), 1);
    rd(0, d, d2); chk("R4 csr overflow bit", d, 8'h30);
    rd(1, d, d2); chk("R4 counter wrapped", d, 8'h00);
    wr(0, 8'h10); chk("R5 clear overflow", W'(irq_o), 0);
  endtask

  task automatic t_set_wins();
    logic [W-1:0] d, d2;
    wr(1, 8'h0F);
    tick = 1'b1; ack_a = 1'b1; @(negedge clk); tick = 1'b0; ack_a = 1'b0;
    chk("R7 set wins over ack", W'(irq_a), 1);
    rd(0, d, d2);
    wr(1, 8'h0F);
    tick = 1'b1; addr = 0; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk("R7 set wins over write", W'(irq_a), 1);
    wr(0, 8'h00); chk("R5 write disarmed flag", W'(irq_a), 1);
    ack_a = 1'b1; @(negedge clk); ack_a = 1'b0;
    chk("R6 ack clears A", W'(irq_a), 0);
  endtask

  task automatic pin_step(input logic [1:0] cnt_reg, input logic [W-1:0] csr,
                          input logic exp, input string tag);
    wr(0, csr); wr(1, 8'(cnt_reg) + 8'h4F); ticks(1);
    chk(tag, W'(pin), W'(exp));
  endtask

  task automatic t_pin();
    wr(2, 8'h50);
    pin_step(0, 8'h02, 1'b1, "R9 A drive high");
    pin_step(0, 8'h00, 1'b1, "R9 A keep");
    pin_step(0, 8'h03, 1'b0, "R9 A toggle to 0");
    pin_step(0, 8'h03, 1'b1, "R9 A toggle to 1");
    pin_step(0, 8'h01, 1'b0, "R9 A drive low");
    wr(3, 8'h70);
    pin_step(2'd0, 8'h08, 1'b0, "R10 no match holds pin");
    wr(0, 8'h08); wr(1, 8'h6F); ticks(1); chk("R9 B drive high", W'(pin), 1);
    wr(0, 8'h04); wr(1, 8'h6F); ticks(1); chk("R9 B drive low", W'(pin), 0);
  endtask

  task automatic t_both();
    wr(2, 8'h60); wr(3, 8'h60);
    wr(0, 8'h06); wr(1, 8'h5F); ticks(1); chk("R10 B low beats A high", W'(pin), 0);
    wr(0, 8'h09); wr(1, 8'h5F); ticks(1); chk("R10 B high beats A low", W'(pin), 1);
    wr(0, 8'h0F); wr(1, 8'h5F); ticks(1); chk("R10 both toggle once", W'(pin), 0);
    wr(0, 8'h0D); wr(1, 8'h5F); ticks(1); chk("R10 B toggle beats A low", W'(pin), 1);
    wr(0, 8'h0E); wr(1, 8'h5F); ticks(1); chk("R10 B toggle beats A high", W'(pin), 0);
  endtask

  task automatic t_variant();
    logic [W-1:0] d, d2;
    wr(0, 8'h00);
    rd(0, d, d2); chk("R12 reserved bit ignores write", d2 & 8'h1F, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_match_a();
    t_clear_rule();
    t_ack();
    t_ovf();
    t_set_wins();
    t_pin();
    t_both();
    t_variant();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule